// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block owns a small descriptor memory and walks the transmit part of it as a ring. The memory has room for 128 descriptors of two 32-bit words each. The first word carries the frame length in its upper half, with control and status flags in its lower half. The second word carries the buffer address. A host fills descriptors over a simple register bus and hands each one to the engine by setting its ready flag. The engine then offers the frame length, the buffer address and the pad and CRC options to a frame transmitter.

The transmitter answers with a one-cycle done strobe that carries a status code. The engine then writes that status into the descriptor, clears the ready flag and raises either a buffer event or an error event, as the descriptor's interrupt flag asks. It then moves on to the next descriptor.

A configuration register sets how many descriptors belong to transmit. Descriptors past that count are left alone, so that a receive ring can use them. A wrap flag in a descriptor also ends the ring early. A transmit enable input gates the engine as a whole.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the engine offers nothing (`frm_req` low), both event outputs are low, the ring position is descriptor 0, and the count register at byte address 0x020 reads 64.
- R2: With `hb_sel` high, the host reads combinationally and writes on the clock edge. Word w (0 or 1) of descriptor i sits at byte address 0x400 + 8*i + 4*w. The count register sits at 0x020. Any other address reads 0.
- R3: While the descriptor at the ring position has word-0 bit 15 (ready) clear, no frame is offered.
- R4: For a ready descriptor the engine raises `frm_req` and presents the following, all held stable until `frm_done`:
  - the length from word-0 bits 31:16;
  - the address from word 1;
  - pad from bit 12;
  - CRC from bit 11.
- R5: On `frm_done`, word 0 of the descriptor is rewritten in a single update:
  - bits 8:0 take `frm_status`;
  - bit 15 is cleared;
  - bits 31:16 and 14:9 are kept.
- R6: After completion the ring position moves to the next descriptor. It returns to descriptor 0 instead when word-0 bit 13 (wrap) was set, or when the completed descriptor was the last one allowed by the count register.
- R7: One cycle after a completion whose bit 14 (interrupt enable) was set, exactly one of the two events pulses for one cycle:
  - `evt_err` when status bit 8 (underrun), bit 3 (retry limit) or bit 2 (late collision) is set;
  - `evt_buf` otherwise.
  When bit 14 is clear, neither event pulses.
- R8: While `tx_en` is low:
  - any pending offer is withdrawn;
  - the ring position returns to descriptor 0;
  - `frm_done` has no effect on the descriptors or the events.
- R9: At most one frame is in flight: `frm_req` is low in the cycle after an accepted `frm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; low parks the ring at descriptor 0 |
| hb_sel | input | 1 | Host bus access strobe |
| hb_wr | input | 1 | Host write when high, read when low |
| hb_addr | input | 11 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, combinational |
| frm_req | output | 1 | A frame is offered to the transmitter |
| frm_len | output | 16 | Offered frame length |
| frm_addr | output | 32 | Offered buffer address |
| frm_pad | output | 1 | Pad short frame option |
| frm_crc | output | 1 | Append CRC option |
| frm_done | input | 1 | Transmitter completion strobe |
| frm_status | input | 9 | Completion status code |
| evt_buf | output | 1 | Good-completion event pulse |
| evt_err | output | 1 | Error-completion event pulse |

## Verification
The assertions rely on the following from the environment:
- the transmitter raises `frm_done` only while `frm_req` is high;
- the host never writes word 0 of the descriptor being completed in the same cycle as the completion.

The stimulus respects both. The responder strobes done only a few cycles after it sees an offer. The host edits only descriptors that are idle or not yet reached, and it writes the ready word last, after the address word. The one deliberate exception is a done strobe while `tx_en` is low, which checks that such a strobe is ignored.

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int              DESC_TOTAL = 128,
  parameter int              AW         = 11,
  parameter logic [AW-1:0]   DESC_BASE  = 11'h400,
  parameter logic [AW-1:0]   CNT_ADDR   = 11'h020,
  parameter logic [31:0]     CNT_RESET  = 32'd64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          hb_sel,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [31:0]   hb_wdata,
  output logic [31:0]   hb_rdata,
  output logic          frm_req,
  output logic [15:0]   frm_len,
  output logic [31:0]   frm_addr,
  output logic          frm_pad,
  output logic          frm_crc,
  input  logic          frm_done,
  input  logic [8:0]    frm_status,
  output logic          evt_buf,
  output logic          evt_err
);
  localparam int WORDS = DESC_TOTAL * 2;
  localparam int IW    = $clog2(WORDS);
  localparam int PW    = $clog2(DESC_TOTAL);
  localparam int CW    = PW + 1;

  logic [31:0]   mem [WORDS];
  logic [31:0]   cfg;
  logic [PW-1:0] ptr;
  logic [15:0]   lat_len;
  logic [5:0]    lat_ctl;

  wire [CW-1:0] tx_cnt  = cfg[CW-1:0];
  wire          in_desc = (hb_addr[AW-1:IW+2] == DESC_BASE[AW-1:IW+2]) && (hb_addr[1:0] == 2'b00);
  wire [IW-1:0] widx    = hb_addr[IW+1:2];
  wire [IW-1:0] w0_idx  = {ptr, 1'b0};
  wire [IW-1:0] w1_idx  = {ptr, 1'b1};
  wire [31:9]   cur_hi  = mem[w0_idx][31:9];

  wire done_fire = frm_req && tx_en && frm_done;
  wire is_err    = frm_status[8] | frm_status[3] | frm_status[2];
  wire last_slot = (CW'(ptr) + CW'(1)) >= tx_cnt;
  wire [PW-1:0] ptr_nxt = (lat_ctl[4] || last_slot) ? '0 : ptr + PW'(1);
  wire [31:0] wb_word = {lat_len, 1'b0, lat_ctl, frm_status};

  assign frm_len = lat_len;
  assign frm_pad = lat_ctl[3];
  assign frm_crc = lat_ctl[2];

  always_comb begin
    hb_rdata = '0;
    if (hb_sel) begin
      if (in_desc)                  hb_rdata = mem[widx];
      else if (hb_addr == CNT_ADDR) hb_rdata = cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (hb_sel && hb_wr && in_desc) mem[widx] <= hb_wdata;
    if (done_fire)                  mem[w0_idx] <= wb_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CNT_RESET;
      ptr      <= '0;
      frm_req  <= 1'b0;
      frm_addr <= '0;
      lat_len  <= '0;
      lat_ctl  <= '0;
      evt_buf  <= 1'b0;
      evt_err  <= 1'b0;
    end else begin
      evt_buf <= 1'b0;
      evt_err <= 1'b0;
      if (hb_sel && hb_wr && hb_addr == CNT_ADDR) cfg <= hb_wdata;
      if (!tx_en) begin
        frm_req <= 1'b0;
        ptr     <= '0;
      end else if (frm_req) begin
        if (frm_done) begin
          frm_req <= 1'b0;
          ptr     <= ptr_nxt;
          evt_buf <= lat_ctl[5] && !is_err;
          evt_err <= lat_ctl[5] && is_err;
        end
      end else if (cur_hi[15] && (CW'(ptr) < tx_cnt)) begin
        lat_len  <= cur_hi[31:16];
        lat_ctl  <= cur_hi[14:9];
        frm_addr <= mem[w1_idx];
        frm_req  <= 1'b1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && tx_en && !frm_done |=> frm_req); // R4
  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && tx_en && !frm_done |=> $stable(frm_addr) && $stable(frm_len)); // R4
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_buf && evt_err)); // R7
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_buf || evt_err) |-> $past(frm_done && frm_req && tx_en)); // R7
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_done && tx_en |=> !frm_req); // R9
  AST_DISABLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !frm_req && ptr == '0 && !evt_buf && !evt_err); // R8
endmodule

// File: tb/sim_tx_desc_ring.sv
`timescale 1ns/1ps
module sim_tx_desc_ring;
  logic clk = 0, rst_n = 0, tx_en = 0;
  logic hb_sel = 0, hb_wr = 0;
  logic [10:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic frm_req, frm_pad, frm_crc, frm_done = 0, evt_buf, evt_err;
  logic [15:0] frm_len;
  logic [31:0] frm_addr;
  logic [8:0]  frm_status = '0;

  tx_desc_ring u0 (.*);

  always #4 clk = ~clk;

  typedef struct { logic [15:0] len; logic [31:0] addr; logic pad, crc, irq; logic [8:0] st; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0, done_cnt = 0, offer_cnt = 0;
  bit hold_done = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] w0(input logic [15:0] len, input bit rdy, irq, wrap, pad, crc, input logic [8:0] st);
    return {len, rdy, irq, wrap, pad, crc, 2'b00, st};
  endfunction

  task automatic hwr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); hb_sel = 1; hb_wr = 1; hb_addr = a; hb_wdata = d;
    @(negedge clk); hb_sel = 0; hb_wr = 0;
  endtask

  task automatic hrd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); hb_sel = 1; hb_wr = 0; hb_addr = a;
    #1 d = hb_rdata;
    hb_sel = 0;
  endtask

  task automatic push(input logic [15:0] len, input logic [31:0] addr, input bit pad, crc, irq, input logic [8:0] st);
    exp_t e;
    e.len = len; e.addr = addr; e.pad = pad; e.crc = crc; e.irq = irq; e.st = st;
    exp_q.push_back(e);
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 400 && done_cnt < n; i++) @(negedge clk);
    chk(done_cnt >= n, "R4 completions reached", done_cnt, n);
  endtask

  function automatic logic [10:0] da(input int i, input int w);
    return 11'(32'h400 + 8*i + 4*w);
  endfunction

  // monitor / responder
  initial begin
    bit prev = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (frm_req && !prev) begin
        offer_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected offer", frm_addr, 0);
        end else begin
          e = exp_q.pop_front();
          chk(frm_len == e.len, "R4 length", frm_len, e.len);
          chk(frm_addr == e.addr, "R4 address", frm_addr, e.addr);
          chk({frm_pad, frm_crc} == {e.pad, e.crc}, "R4 options", {frm_pad, frm_crc}, {e.pad, e.crc});
          if (!hold_done) begin
            @(negedge clk); @(negedge clk);
            chk(frm_req && frm_addr == e.addr, "R4 offer held", frm_addr, e.addr);
            frm_done = 1; frm_status = e.st;
            @(negedge clk);
            frm_done = 0;
            chk(evt_buf == (e.irq && !(e.st[8] | e.st[3] | e.st[2])), "R7 evt_buf", evt_buf, 0);
            chk(evt_err == (e.irq && (e.st[8] | e.st[3] | e.st[2])), "R7 evt_err", evt_err, 0);
            chk(!frm_req, "R9 gap after done", frm_req, 0);
            done_cnt++;
          end
        end
      end
      prev = frm_req;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!frm_req && !evt_buf && !evt_err, "R1 idle outputs", {frm_req, evt_buf, evt_err}, 0);
    hrd(11'h020, d); chk(d == 64, "R1 count reset", d, 64);
    hrd(11'h100, d); chk(d == 0, "R2 unmapped read", d, 0);
    hwr(11'h020, 4);
    hrd(11'h020, d); chk(d == 4, "R2 count write", d, 4);
    hwr(da(0, 1), 32'hABCD0000);
    hrd(da(0, 1), d); chk(d == 32'hABCD0000, "R2 descriptor readback", d, 32'hABCD0000);
    hwr(da(0, 0), w0(100, 0, 1, 0, 0, 1, 0));
    tx_en = 1;
    repeat (10) @(negedge clk);
    chk(!frm_req && offer_cnt == 0, "R3 not ready stalls", frm_req, 0);

    // four-descriptor ring, ended by the count register
    hwr(da(3, 1), 32'h4000); hwr(da(3, 0), w0(60, 1, 1, 0, 1, 1, 9'h1FF));
    hwr(da(2, 1), 32'h3000); hwr(da(2, 0), w0(1500, 1, 0, 0, 0, 0, 9'h1FF));
    hwr(da(1, 1), 32'h2000); hwr(da(1, 0), w0(40, 1, 1, 0, 1, 0, 9'h1FF));
    push(100, 32'h1000, 0, 1, 1, 9'h030);
    push(40, 32'h2000, 1, 0, 1, 9'h100);
    push(1500, 32'h3000, 0, 0, 0, 9'h008);
    push(60, 32'h4000, 1, 1, 1, 9'h003);
    hwr(da(0, 1), 32'h1000); hwr(da(0, 0), w0(100, 1, 1, 0, 0, 1, 9'h1FF));
    wait_done(4);
    repeat (10) @(negedge clk);
    hrd(da(0, 0), d); chk(d == w0(100, 0, 1, 0, 0, 1, 9'h030), "R5 writeback d0", d, w0(100, 0, 1, 0, 0, 1, 9'h030));
    hrd(da(1, 0), d); chk(d == w0(40, 0, 1, 0, 1, 0, 9'h100), "R5 writeback d1", d, w0(40, 0, 1, 0, 1, 0, 9'h100));
    hrd(da(2, 0), d); chk(d == w0(1500, 0, 0, 0, 0, 0, 9'h008), "R5 writeback d2", d, w0(1500, 0, 0, 0, 0, 0, 9'h008));
    hrd(da(3, 0), d); chk(d == w0(60, 0, 1, 0, 1, 1, 9'h003), "R5 writeback d3", d, w0(60, 0, 1, 0, 1, 1, 9'h003));

    // wrap bit on descriptor 0 (offer of d0 also shows the count wrap, R6)
    hwr(da(1, 1), 32'h7100); hwr(da(1, 0), w0(64, 1, 1, 0, 0, 0, 0));
    push(200, 32'h7000, 0, 0, 1, 9'h000);
    hwr(da(0, 1), 32'h7000); hwr(da(0, 0), w0(200, 1, 1, 1, 0, 0, 0));
    wait_done(5);
    repeat (12) @(negedge clk);
    hrd(da(1, 0), d); chk(d[15] == 1'b1, "R6 wrap skips d1", d, w0(64, 1, 1, 0, 0, 0, 0));
    push(201, 32'h7000, 0, 0, 1, 9'h004);
    push(64, 32'h7100, 0, 0, 1, 9'h000);
    hwr(da(0, 0), w0(201, 1, 1, 0, 0, 0, 0));
    wait_done(7);

    // disable while a frame is offered
    hold_done = 1;
    push(90, 32'h5000, 0, 0, 1, 9'h000);
    hwr(da(2, 1), 32'h5000); hwr(da(2, 0), w0(90, 1, 1, 0, 0, 0, 0));
    for (int i = 0; i < 100 && offer_cnt < 8; i++) @(negedge clk);
    chk(offer_cnt == 8, "R8 offer seen", offer_cnt, 8);
    @(negedge clk); tx_en = 0;
    @(negedge clk);
    chk(!frm_req, "R8 offer withdrawn", frm_req, 0);
    frm_done = 1; frm_status = 9'h000;
    @(negedge clk); frm_done = 0;
    chk(!evt_buf && !evt_err, "R8 done ignored events", {evt_buf, evt_err}, 0);
    hrd(da(2, 0), d); chk(d == w0(90, 1, 1, 0, 0, 0, 0), "R8 no writeback", d, w0(90, 1, 1, 0, 0, 0, 0));
    hold_done = 0;
    push(80, 32'h6000, 1, 1, 1, 9'h000);
    hwr(da(0, 1), 32'h6000); hwr(da(0, 0), w0(80, 1, 1, 0, 1, 1, 0));
    tx_en = 1;
    wait_done(8);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 ring restarts at 0", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule